// File: doc/BRIEF.md
# Endpoint Buffer Ready and Flush Tracker

This block keeps the per-endpoint buffer state of a USB device-mode controller with six endpoints in each direction. Software primes an endpoint buffer by writing a one to its bit in the prime register. The request is held and shown to the DMA side until that side answers with a one-cycle `prime_done` pulse. The buffer is then marked ready in the read-only status register. It stays ready until the DMA side retires it, software flushes it, or the USB bus is reset.

A flush write cancels pending and ready buffers on the chosen endpoints. When the packet engine reports a packet still in progress on such an endpoint, the flush waits and its bit stays visible until the packet ends. The bit then clears by itself. A prime written while a buffer is already ready is queued. When the ready buffer is retired, the endpoint falls back to pending, so the ready bit drops briefly before the next `prime_done` sets it again.

Each of the twelve buffer slots runs a four-state machine:
- **EMPTY**: nothing primed.
- **WAIT**: prime pending.
- **READY**: buffer ready.
- **HOLD**: flush waiting for a busy packet to end.

The transitions are:
- EMPTY→WAIT on a prime write.
- WAIT→READY on `prime_done`.
- READY→EMPTY on retire with nothing queued.
- READY→WAIT on retire with a prime queued (the re-prime).
- EMPTY/WAIT/READY→EMPTY on a flush while idle.
- EMPTY/WAIT/READY→HOLD on a flush while busy.
- HOLD→EMPTY when busy falls.
- Any state→EMPTY on bus reset.

Top module: `ep_buf_ctrl`

## Requirements
- R1: Registers sit at prime 0x1B0, flush 0x1B4 and status 0x1B8. Every register uses the same bit layout: bits 21:16 are transmit endpoints 0..5 (bit 21 = endpoint 5), and bits 5:0 are receive endpoints 0..5. All other bits, and all other addresses, read zero. After reset all three registers read zero.
- R2: Writing a one to a prime bit makes that endpoint pending. The prime register then reads one for that bit, and `tx_prime_req`/`rx_prime_req` assert for it. A zero bit in the write has no effect.
- R3: A `prime_done` pulse on a pending endpoint sets its ready bit and clears its pending bit, both in the following cycle. A `prime_done` pulse on an endpoint that is not pending is ignored.
- R4: A retire pulse on a ready endpoint clears its ready bit in the following cycle. A retire pulse on an endpoint that is not ready is ignored.
- R5: A prime written while an endpoint is ready is queued and keeps the ready bit set. A later retire clears ready and leaves the endpoint pending. The next `prime_done` sets ready again.
- R6: A flush write on an endpoint whose busy input is low clears its ready and pending bits in the next cycle. The flush bit then reads zero.
- R7: A flush write on an endpoint whose busy input is high clears ready at once. The flush bit reads one while busy stays high, and reads zero in the cycle after busy falls.
- R8: A flush write and a `prime_done` pulse on the same endpoint in the same cycle leave the ready bit cleared.
- R9: Zero bits in a flush write, and any write to the status register, change no state.
- R10: A USB bus reset pulse clears every ready, pending and flush bit in the next cycle.
- R11: While `dev_mode` is low, register writes are ignored and reads return zero. The stored state reappears when `dev_mode` returns high.
- R12: While a flush is waiting on a busy endpoint, a prime write, a `prime_done` pulse and a retire pulse on that endpoint are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_mode | input | 1 | High when the controller runs as a device |
| bus_reset | input | 1 | One-cycle USB bus reset pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Register address for reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr`, combinational |
| tx_prime_req | output | NUM_EP (6) | Transmit endpoints with a prime pending |
| rx_prime_req | output | NUM_EP (6) | Receive endpoints with a prime pending |
| tx_prime_done | input | NUM_EP (6) | DMA pulse: transmit buffer primed |
| rx_prime_done | input | NUM_EP (6) | DMA pulse: receive buffer primed |
| tx_retire | input | NUM_EP (6) | DMA pulse: transmit buffer retired |
| rx_retire | input | NUM_EP (6) | DMA pulse: receive buffer retired |
| tx_busy | input | NUM_EP (6) | Packet in progress on a transmit endpoint |
| rx_busy | input | NUM_EP (6) | Packet in progress on a receive endpoint |

## Verification
Several rules are checked on every cycle across all twelve slots:
- Bus reset empties every slot.
- A ready bit only rises on a slot that was pending.
- Retire and flush drop ready.
- A waiting flush holds while busy stays high.

Only the directed scenarios can show the register encodings and the effect of `dev_mode` on reads. They also cover the queued re-prime sequence with its one-cycle gap, and the pulses that are ignored during a held flush, since those need chosen sequences of writes and pulses.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;

    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_WAIT  = 2'd1,
        SL_READY = 2'd2,
        SL_HOLD  = 2'd3
    } slot_state_e;

    localparam logic [31:0] OFS_PRIME  = 32'h0000_01B0;
    localparam logic [31:0] OFS_FLUSH  = 32'h0000_01B4;
    localparam logic [31:0] OFS_STATUS = 32'h0000_01B8;
    localparam int          TX_LSB     = 16;

endpackage

// File: rtl/ep_buf_slot.sv
module ep_buf_slot
    import ep_buf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic prime_set,
    input  logic flush_set,
    input  logic prime_done,
    input  logic retire,
    input  logic busy,
    output logic ready,
    output logic pending,
    output logic flushing
);

    slot_state_e state_q, state_d;
    logic        queued_q, queued_d;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        queued_d = queued_q;
        if (bus_reset) begin
            state_d  = SL_EMPTY;
            queued_d = 1'b0;
        end else begin
            unique case (state_q)
                SL_EMPTY: begin
                    if (flush_set)      state_d = busy ? SL_HOLD : SL_EMPTY;
                    else if (prime_set) state_d = SL_WAIT;
                end
                SL_WAIT: begin
                    if (flush_set)       state_d = busy ? SL_HOLD : SL_EMPTY;
                    else if (prime_done) state_d = SL_READY;
                end
                SL_READY: begin
                    if (flush_set) begin
                        state_d  = busy ? SL_HOLD : SL_EMPTY;
                        queued_d = 1'b0;
                    end else if (retire) begin
                        state_d  = (queued_q || prime_set) ? SL_WAIT : SL_EMPTY;
                        queued_d = 1'b0;
                    end else if (prime_set) begin
                        queued_d = 1'b1;
                    end
                end
                SL_HOLD: begin
                    if (!busy) state_d = SL_EMPTY;
                end
                default: state_d = SL_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SL_EMPTY;
            queued_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            queued_q <= queued_d;
        end
    end

    // outputs
    always_comb begin
        ready    = (state_q == SL_READY);
        pending  = (state_q == SL_WAIT) || queued_q;
        flushing = (state_q == SL_HOLD);
    end

endmodule

// File: rtl/ep_buf_regif.sv
module ep_buf_regif
    import ep_buf_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int ADDR_W = 12,
    localparam int NSLOT = 2 * NUM_EP
) (
    input  logic              dev_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic [NSLOT-1:0]  ready_v,
    input  logic [NSLOT-1:0]  pend_v,
    input  logic [NSLOT-1:0]  flush_v,
    output logic [NSLOT-1:0]  prime_set,
    output logic [NSLOT-1:0]  flush_set,
    output logic [31:0]       rd_data
);

    logic sel_prime, sel_flush, sel_status;
    logic [NSLOT-1:0] wr_slots;
    logic [31:0] pend_w, flush_w, ready_w;
    logic unused_bits;

    assign sel_prime  = (addr == OFS_PRIME[ADDR_W-1:0]);
    assign sel_flush  = (addr == OFS_FLUSH[ADDR_W-1:0]);
    assign sel_status = (addr == OFS_STATUS[ADDR_W-1:0]);
    assign unused_bits = ^wr_data;

    // slot index: 0..NUM_EP-1 receive, NUM_EP..NSLOT-1 transmit
    always_comb begin
        pend_w  = '0;
        flush_w = '0;
        ready_w = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            wr_slots[i]          = wr_data[i];
            wr_slots[NUM_EP + i] = wr_data[TX_LSB + i];
            pend_w[i]            = pend_v[i];
            pend_w[TX_LSB + i]   = pend_v[NUM_EP + i];
            flush_w[i]           = flush_v[i];
            flush_w[TX_LSB + i]  = flush_v[NUM_EP + i];
            ready_w[i]           = ready_v[i];
            ready_w[TX_LSB + i]  = ready_v[NUM_EP + i];
        end
    end

    assign prime_set = (dev_mode && wr_en && sel_prime) ? wr_slots : '0;
    assign flush_set = (dev_mode && wr_en && sel_flush) ? wr_slots : '0;

    always_comb begin
        rd_data = '0;
        if (dev_mode) begin
            if (sel_prime)       rd_data = pend_w;
            else if (sel_flush)  rd_data = flush_w;
            else if (sel_status) rd_data = ready_w;
        end
    end

endmodule

// File: rtl/ep_buf_ctrl.sv
module ep_buf_ctrl
    import ep_buf_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_mode,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [NUM_EP-1:0] tx_prime_req,
    output logic [NUM_EP-1:0] rx_prime_req,
    input  logic [NUM_EP-1:0] tx_prime_done,
    input  logic [NUM_EP-1:0] rx_prime_done,
    input  logic [NUM_EP-1:0] tx_retire,
    input  logic [NUM_EP-1:0] rx_retire,
    input  logic [NUM_EP-1:0] tx_busy,
    input  logic [NUM_EP-1:0] rx_busy
);

    localparam int NSLOT = 2 * NUM_EP;

    logic [NSLOT-1:0] prime_set, flush_set;
    logic [NSLOT-1:0] done_v, retire_v, busy_v;
    logic [NSLOT-1:0] ready_v, pend_v, flush_v;

    assign done_v   = {tx_prime_done, rx_prime_done};
    assign retire_v = {tx_retire, rx_retire};
    assign busy_v   = {tx_busy, rx_busy};

    ep_buf_regif #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_regif (
        .dev_mode  (dev_mode),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .ready_v   (ready_v),
        .pend_v    (pend_v),
        .flush_v   (flush_v),
        .prime_set (prime_set),
        .flush_set (flush_set),
        .rd_data   (rd_data)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        ep_buf_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .bus_reset  (bus_reset),
            .prime_set  (prime_set[s]),
            .flush_set  (flush_set[s]),
            .prime_done (done_v[s]),
            .retire     (retire_v[s]),
            .busy       (busy_v[s]),
            .ready      (ready_v[s]),
            .pending    (pend_v[s]),
            .flushing   (flush_v[s])
        );
    end

    assign rx_prime_req = pend_v[NUM_EP-1:0];
    assign tx_prime_req = pend_v[NSLOT-1:NUM_EP];

endmodule

// File: rtl/ep_buf_ctrl_chk.sv
module ep_buf_ctrl_chk #(
    parameter int NSLOT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic [NSLOT-1:0] flush_set,
    input logic [NSLOT-1:0] retire_v,
    input logic [NSLOT-1:0] busy_v,
    input logic [NSLOT-1:0] ready_v,
    input logic [NSLOT-1:0] pend_v,
    input logic [NSLOT-1:0] flush_v
);

    a_r10_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (ready_v == '0 && pend_v == '0 && flush_v == '0));

    a_r3_ready_needs_prime: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_v & ~$past(ready_v) & ~$past(pend_v)) == '0));

    a_r4_retire_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|(retire_v & ready_v)) |=> (($past(retire_v & ready_v) & ready_v) == '0));

    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset) |=> (($past(flush_v & busy_v) & ~flush_v) == '0));

    a_r6_idle_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flush_set & ~busy_v)) |=>
            (($past(flush_set & ~busy_v) & (ready_v | pend_v | flush_v)) == '0));

    a_r8_flush_beats_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_set) |=> (($past(flush_set) & ready_v) == '0));

endmodule

bind ep_buf_ctrl ep_buf_ctrl_chk #(.NSLOT(2 * NUM_EP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .flush_set (flush_set),
    .retire_v  (retire_v),
    .busy_v    (busy_v),
    .ready_v   (ready_v),
    .pend_v    (pend_v),
    .flush_v   (flush_v)
);

// File: tb/ep_buf_ctrl_tb.sv
module ep_buf_ctrl_tb;

    localparam logic [11:0] A_PRIME  = 12'h1B0;
    localparam logic [11:0] A_FLUSH  = 12'h1B4;
    localparam logic [11:0] A_STATUS = 12'h1B8;

    logic clk = 1'b0, rst_n = 1'b0, dev_mode = 1'b1, bus_reset = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [5:0] tx_prime_req, rx_prime_req;
    logic [5:0] tx_prime_done = '0, rx_prime_done = '0, tx_retire = '0, rx_retire = '0;
    logic [5:0] tx_busy = '0, rx_busy = '0;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    ep_buf_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dev_mode(dev_mode), .bus_reset(bus_reset),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .tx_prime_req(tx_prime_req), .rx_prime_req(rx_prime_req),
        .tx_prime_done(tx_prime_done), .rx_prime_done(rx_prime_done),
        .tx_retire(tx_retire), .rx_retire(rx_retire),
        .tx_busy(tx_busy), .rx_busy(rx_busy)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] td, input logic [5:0] rdn,
                         input logic [5:0] tr, input logic [5:0] rr);
        @(negedge clk);
        tx_prime_done = td; rx_prime_done = rdn; tx_retire = tr; rx_retire = rr;
        @(negedge clk);
        tx_prime_done = '0; rx_prime_done = '0; tx_retire = '0; rx_retire = '0;
    endtask

    task automatic do_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 prime reset", A_PRIME, 32'h0);
        rd_chk("R1 flush reset", A_FLUSH, 32'h0);
        rd_chk("R1 status reset", A_STATUS, 32'h0);
        rd_chk("R1 unmapped addr", 12'h1BC, 32'h0);
    endtask

    task automatic t_prime();
        wr(A_PRIME, 32'h0002_0001);
        rd_chk("R2 prime pending", A_PRIME, 32'h0002_0001);
        chk("R2 prime req", {20'h0, tx_prime_req, rx_prime_req}, 32'h0000_0081);
        wr(A_PRIME, 32'h0);
        rd_chk("R2 zero write", A_PRIME, 32'h0002_0001);
        pulse(6'h00, 6'h01, 6'h00, 6'h00);
        rd_chk("R3 rx0 ready", A_STATUS, 32'h0000_0001);
        rd_chk("R3 rx0 pend cleared", A_PRIME, 32'h0002_0000);
        pulse(6'h08, 6'h00, 6'h00, 6'h00);
        rd_chk("R3 stray done ignored", A_STATUS, 32'h0000_0001);
        pulse(6'h02, 6'h00, 6'h00, 6'h00);
        rd_chk("R3 tx1 ready", A_STATUS, 32'h0002_0001);
    endtask

    task automatic t_retire();
        pulse(6'h00, 6'h00, 6'h00, 6'h01);
        rd_chk("R4 rx0 retired", A_STATUS, 32'h0002_0000);
        pulse(6'h20, 6'h00, 6'h20, 6'h01);
        rd_chk("R4 stray retire ignored", A_STATUS, 32'h0002_0000);
    endtask

    task automatic t_reprime();
        wr(A_PRIME, 32'h0002_0000);
        rd_chk("R5 queued keeps ready", A_STATUS, 32'h0002_0000);
        rd_chk("R5 queued pending", A_PRIME, 32'h0002_0000);
        pulse(6'h00, 6'h00, 6'h02, 6'h00);
        rd_chk("R5 ready drops", A_STATUS, 32'h0);
        rd_chk("R5 back to pending", A_PRIME, 32'h0002_0000);
        pulse(6'h02, 6'h00, 6'h00, 6'h00);
        rd_chk("R5 ready again", A_STATUS, 32'h0002_0000);
        rd_chk("R5 pend cleared", A_PRIME, 32'h0);
    endtask

    task automatic t_flush_idle();
        wr(A_PRIME, 32'h0000_0004);
        wr(A_FLUSH, 32'h0002_0004);
        rd_chk("R6 ready cleared", A_STATUS, 32'h0);
        rd_chk("R6 pend cleared", A_PRIME, 32'h0);
        rd_chk("R6 flush done", A_FLUSH, 32'h0);
    endtask

    task automatic t_flush_busy();
        wr(A_PRIME, 32'h0000_0008);
        pulse(6'h00, 6'h08, 6'h00, 6'h00);
        rd_chk("R7 rx3 ready", A_STATUS, 32'h0000_0008);
        @(negedge clk);
        rx_busy = 6'h08;
        wr(A_FLUSH, 32'h0000_0008);
        rd_chk("R7 flush held", A_FLUSH, 32'h0000_0008);
        rd_chk("R7 ready dropped", A_STATUS, 32'h0);
        wr(A_PRIME, 32'h0000_0008);
        rd_chk("R12 prime ignored", A_PRIME, 32'h0);
        pulse(6'h00, 6'h08, 6'h00, 6'h08);
        rd_chk("R12 done ignored", A_STATUS, 32'h0);
        rd_chk("R12 still held", A_FLUSH, 32'h0000_0008);
        @(negedge clk);
        rx_busy = 6'h00;
        rd_chk("R7 held until edge", A_FLUSH, 32'h0000_0008);
        @(negedge clk);
        rd_chk("R7 flush released", A_FLUSH, 32'h0);
    endtask

    task automatic t_race();
        wr(A_PRIME, 32'h0000_0010);
        @(negedge clk);
        wr_en = 1'b1; addr = A_FLUSH; wr_data = 32'h0000_0010; rx_prime_done = 6'h10;
        @(negedge clk);
        wr_en = 1'b0; rx_prime_done = '0;
        rd_chk("R8 flush wins", A_STATUS, 32'h0);
        rd_chk("R8 pend gone", A_PRIME, 32'h0);
    endtask

    task automatic t_nop();
        wr(A_PRIME, 32'h0000_0002);
        pulse(6'h00, 6'h02, 6'h00, 6'h00);
        wr(A_FLUSH, 32'h0);
        rd_chk("R9 zero flush", A_STATUS, 32'h0000_0002);
        wr(A_STATUS, 32'hFFFF_FFFF);
        rd_chk("R9 status write", A_STATUS, 32'h0000_0002);
        wr(A_PRIME, 32'hFFFF_FFFF);
        rd_chk("R1 reserved zero", A_PRIME, 32'h003F_003F);
    endtask

    task automatic t_bus_reset();
        do_bus_reset();
        rd_chk("R10 status", A_STATUS, 32'h0);
        rd_chk("R10 prime", A_PRIME, 32'h0);
        chk("R10 prime req", {20'h0, tx_prime_req, rx_prime_req}, 32'h0);
    endtask

    task automatic t_mode();
        wr(A_PRIME, 32'h0000_0001);
        pulse(6'h00, 6'h01, 6'h00, 6'h00);
        @(negedge clk);
        dev_mode = 1'b0;
        rd_chk("R11 read zero", A_STATUS, 32'h0);
        wr(A_FLUSH, 32'h0000_0001);
        wr(A_PRIME, 32'h0020_0000);
        @(negedge clk);
        dev_mode = 1'b1;
        rd_chk("R11 state kept", A_STATUS, 32'h0000_0001);
        rd_chk("R11 prime ignored", A_PRIME, 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prime();
        t_retire();
        t_reprime();
        t_flush_idle();
        t_flush_busy();
        t_race();
        t_nop();
        t_bus_reset();
        t_mode();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule